// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block sits beside the fetch stage of a 32-bit in-order core and chooses the next fetch address. It holds a direct-mapped table of 2^IDX_BITS entries. Each entry keeps four things: a valid bit, the full address of a branch instruction, that branch's target and a 2-bit saturating counter.

In target mode the block looks up the current fetch address in the table. When the entry hits and its counter leans taken, the block returns the stored target in the same cycle. A correctly predicted taken branch then costs no bubbles.

The block also has three lighter modes, chosen with `pred_mode`:
- **None** gives no prediction.
- **Static** makes a decode-stage guess from the sign of the offset and the jump type.
- **History** makes a decode-stage guess from the counters alone, with no stored target.

When the execute stage resolves a branch, it reports the branch on the resolve port. The block then trains the table. It also tells the pipeline whether the path that was fetched was wrong and which address is correct.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid. In target mode (`pred_mode`=3), before any resolve, `fetch_next` is `fetch_pc`+4 and `fetch_taken` is 0 for every address.
- R2: In target mode an entry is selected by `fetch_pc[IDX_BITS+1:2]`. It hits when its valid bit is set and its stored PC equals all 32 bits of `fetch_pc`. A hit with counter 2 or 3 drives `fetch_taken`=1 and `fetch_next`=stored target in the same cycle. Otherwise `fetch_next`=`fetch_pc`+4.
- R3: In target mode, a taken resolve whose PC does not hit writes the entry at the edge: valid set, PC and target stored, counter set to 2. A not-taken resolve that does not hit changes nothing.
- R4: In target mode, a resolve that hits rewrites the stored target. It moves the counter up by one when taken and down by one when not taken, saturating at 0 and 3.
- R5: `resolve_next` is `upd_target` when `upd_taken` is 1, else `upd_pc`+4. `mispredict` is 1 exactly when `upd_valid` is 1 and `resolve_next` differs from `upd_pred_next`.
- R6: In static mode (`pred_mode`=1), `dec_redirect` is 1 when `dec_valid` is 1 and either `dec_is_jal` is 1 or `dec_is_cond` is 1 with `dec_offset[31]`=1 (backward). `dec_target`=`dec_pc`+`dec_offset`. `fetch_taken` stays 0.
- R7: In history mode (`pred_mode`=2), the counter at `upd_pc[IDX_BITS+1:2]` moves on every resolve, saturating, with no tag check. Counters reset to 1. A valid `dec_is_jal` always redirects. A valid `dec_is_cond` redirects when the counter at `dec_pc[IDX_BITS+1:2]` is 2 or 3. `fetch_taken` stays 0.
- R8: In none mode (`pred_mode`=0), `fetch_taken` and `dec_redirect` stay 0. In none and static modes, resolves leave the table unchanged, as later target-mode fetches show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_mode | input | 2 | 0 none, 1 static, 2 history, 3 target |
| fetch_pc | input | XLEN | Current fetch address |
| fetch_next | output | XLEN | Predicted next fetch address |
| fetch_taken | output | 1 | Fetch-stage taken prediction |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_is_cond | input | 1 | Decoded instruction is a conditional branch |
| dec_is_jal | input | 1 | Decoded instruction is a direct jump-and-link |
| dec_pc | input | XLEN | Address of the decoded instruction |
| dec_offset | input | XLEN | Sign-extended branch offset |
| dec_redirect | output | 1 | Decode-stage taken prediction |
| dec_target | output | XLEN | Decode-stage predicted target |
| upd_valid | input | 1 | Resolve strobe |
| upd_pc | input | XLEN | Address of the resolved branch |
| upd_target | input | XLEN | Actual branch target |
| upd_taken | input | 1 | Actual outcome |
| upd_pred_next | input | XLEN | Next address that was fetched after the branch |
| mispredict | output | 1 | Fetched path was wrong |
| resolve_next | output | XLEN | Correct next address |

## Verification
The assertions check every cycle that:
- none mode and static mode never raise a fetch redirect;
- a forward conditional branch never redirects in static mode;
- an idle resolve port never signals a mispredict;
- no fetch redirect appears before the first resolve;
- a fetch that is not predicted taken always falls through to PC+4.

Only the bench's scenarios can show the rest. These are how the table learns and forgets: allocation seeding the counter, saturation at both ends, and an aliasing address evicting an entry. The bench covers them by sweeping long sequences of resolves over aliasing addresses against an arithmetic model.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int IDX_BITS = 4,
  parameter int XLEN     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pred_mode,
  input  logic [XLEN-1:0] fetch_pc,
  output logic [XLEN-1:0] fetch_next,
  output logic            fetch_taken,
  input  logic            dec_valid,
  input  logic            dec_is_cond,
  input  logic            dec_is_jal,
  input  logic [XLEN-1:0] dec_pc,
  input  logic [XLEN-1:0] dec_offset,
  output logic            dec_redirect,
  output logic [XLEN-1:0] dec_target,
  input  logic            upd_valid,
  input  logic [XLEN-1:0] upd_pc,
  input  logic [XLEN-1:0] upd_target,
  input  logic            upd_taken,
  input  logic [XLEN-1:0] upd_pred_next,
  output logic            mispredict,
  output logic [XLEN-1:0] resolve_next
);
  localparam int DEPTH = 1 << IDX_BITS;
  localparam logic [1:0] M_NONE = 2'd0, M_STATIC = 2'd1, M_HIST = 2'd2, M_TARGET = 2'd3;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [DEPTH-1:0] ent_vld;
  logic [XLEN-1:0]  ent_tag [DEPTH];
  logic [XLEN-1:0]  ent_tgt [DEPTH];
  logic [1:0]       ent_ctr [DEPTH];

  logic [IDX_BITS-1:0] f_idx, d_idx, u_idx;
  assign f_idx = fetch_pc[IDX_BITS+1:2];
  assign d_idx = dec_pc[IDX_BITS+1:2];
  assign u_idx = upd_pc[IDX_BITS+1:2];

  logic f_hit;
  assign f_hit       = ent_vld[f_idx] && (ent_tag[f_idx] == fetch_pc);
  assign fetch_taken = (pred_mode == M_TARGET) && f_hit && ent_ctr[f_idx][1];
  assign fetch_next  = fetch_taken ? ent_tgt[f_idx] : fetch_pc + STEP;

  logic stat_take, hist_take;
  assign stat_take    = dec_is_jal || (dec_is_cond && dec_offset[XLEN-1]);
  assign hist_take    = dec_is_jal || (dec_is_cond && ent_ctr[d_idx][1]);
  assign dec_target   = dec_pc + dec_offset;
  assign dec_redirect = dec_valid && (((pred_mode == M_STATIC) && stat_take) ||
                                      ((pred_mode == M_HIST) && hist_take));

  assign resolve_next = upd_taken ? upd_target : upd_pc + STEP;
  assign mispredict   = upd_valid && (resolve_next != upd_pred_next);

  logic       u_hit, u_write, u_ctr_en;
  logic [1:0] u_ctr, u_ctr_nxt;
  assign u_hit   = ent_vld[u_idx] && (ent_tag[u_idx] == upd_pc);
  assign u_ctr   = ent_ctr[u_idx];
  assign u_write = upd_valid && (pred_mode == M_TARGET) && (u_hit || upd_taken);

  always_comb begin
    if (upd_taken) u_ctr_nxt = (u_ctr == 2'd3) ? u_ctr : u_ctr + 2'd1;
    else           u_ctr_nxt = (u_ctr == 2'd0) ? u_ctr : u_ctr - 2'd1;
    if (pred_mode == M_HIST) u_ctr_en = upd_valid;
    else                     u_ctr_en = u_write;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      for (int i = 0; i < DEPTH; i++) ent_ctr[i] <= 2'd1;
    end else begin
      if (u_write) ent_vld[u_idx] <= 1'b1;
      if (u_ctr_en) begin
        if (pred_mode == M_TARGET && !u_hit) ent_ctr[u_idx] <= 2'd2;
        else                                 ent_ctr[u_idx] <= u_ctr_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (u_write) begin
      ent_tag[u_idx] <= upd_pc;
      ent_tgt[u_idx] <= upd_target;
    end
  end

  logic unused_none;
  assign unused_none = (M_NONE == 2'd0);
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      pred_mode,
  input logic [XLEN-1:0] fetch_pc,
  input logic [XLEN-1:0] fetch_next,
  input logic            fetch_taken,
  input logic            dec_valid,
  input logic            dec_is_cond,
  input logic            dec_is_jal,
  input logic [XLEN-1:0] dec_offset,
  input logic            dec_redirect,
  input logic            upd_valid,
  input logic            mispredict
);
  logic seen_upd;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_upd <= 1'b0;
    else if (upd_valid) seen_upd <= 1'b1;
  end

  a_r1_quiet_until_trained: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_upd |-> !fetch_taken);
  a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_taken |-> fetch_next == fetch_pc + XLEN'(4));
  a_r5_idle_no_mispredict: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !mispredict);
  a_r6_static_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pred_mode == 2'd1 |-> !fetch_taken);
  a_r6_forward_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_mode == 2'd1 && dec_valid && dec_is_cond && !dec_is_jal && !dec_offset[XLEN-1]) |-> !dec_redirect);
  a_r8_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pred_mode == 2'd0 |-> (!fetch_taken && !dec_redirect));
endmodule

bind btb_predictor btb_predictor_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .pred_mode(pred_mode), .fetch_pc(fetch_pc),
  .fetch_next(fetch_next), .fetch_taken(fetch_taken), .dec_valid(dec_valid),
  .dec_is_cond(dec_is_cond), .dec_is_jal(dec_is_jal), .dec_offset(dec_offset),
  .dec_redirect(dec_redirect), .upd_valid(upd_valid), .mispredict(mispredict)
);

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb_top;
  localparam int N = 2;
  localparam int D = 1 << N;

  logic clk = 0, rst_n = 0;
  logic [1:0] pred_mode = 2'd3;
  logic [31:0] fetch_pc = 0, fetch_next;
  logic fetch_taken;
  logic dec_valid = 0, dec_is_cond = 0, dec_is_jal = 0;
  logic [31:0] dec_pc = 0, dec_offset = 0, dec_target;
  logic dec_redirect;
  logic upd_valid = 0, upd_taken = 0;
  logic [31:0] upd_pc = 0, upd_target = 0, upd_pred_next = 0, resolve_next;
  logic mispredict;

  always #2 clk = ~clk;

  btb_predictor #(.IDX_BITS(N), .XLEN(32)) dut_i (.*);

  int checks = 0, errors = 0;
  logic        m_vld [D];
  logic [31:0] m_tag [D], m_tgt [D];
  int          m_ctr [D];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] pc_of(int k);
    return ((k < 4) ? 32'h1000 : 32'h2000) + 32'(k % 4) * 4;
  endfunction

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    for (int i = 0; i < D; i++) begin m_vld[i] = 0; m_ctr[i] = 1; m_tag[i] = 0; m_tgt[i] = 0; end
  endtask

  function automatic logic [31:0] model_fetch(logic [31:0] pc);
    int i = int'(pc[N+1:2]);
    if (m_vld[i] && m_tag[i] == pc && m_ctr[i] >= 2) return m_tgt[i];
    return pc + 4;
  endfunction

  function automatic int sat(int c, logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic resolve(logic [31:0] pc, logic [31:0] tgt, logic tk, logic [31:0] pn);
    logic [31:0] act;
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_target = tgt; upd_taken = tk; upd_pred_next = pn;
    #1;
    act = tk ? tgt : pc + 4;
    chk("R5 resolve_next", resolve_next, act);
    chk("R5 mispredict", {31'b0, mispredict}, {31'b0, act != pn});
    @(posedge clk); #1 upd_valid = 0;
  endtask

  task automatic fetch_sweep(string r);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] e;
      @(negedge clk); fetch_pc = pc_of(k); #1;
      e = model_fetch(pc_of(k));
      chk(r, fetch_next, e);
      chk(r, {31'b0, fetch_taken}, {31'b0, e != pc_of(k) + 4});
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    pred_mode = 3;
    fetch_sweep("R1 reset empty");

    // R8: none and static modes leave the table untouched
    pred_mode = 0;
    resolve(pc_of(0), 32'h3000, 1, pc_of(0) + 4);
    @(negedge clk); dec_valid = 1; dec_is_jal = 1; dec_pc = 32'h1000; dec_offset = -32'sd16; #1;
    chk("R8 none decode quiet", {31'b0, dec_redirect}, 0);
    dec_valid = 0; dec_is_jal = 0;
    pred_mode = 1;
    resolve(pc_of(1), 32'h3100, 1, pc_of(1) + 4);
    pred_mode = 3;
    fetch_sweep("R8 no table change");

    // R2 R3 R4: target-mode training sweep
    for (int it = 0; it < 400; it++) begin
      int k, i;
      logic tk;
      logic [31:0] pc, tgt;
      step_lf();
      k = int'(lf[2:0]); tk = lf[5] | lf[9]; if (it % 50 > 40) tk = 0;
      pc = pc_of(k); tgt = 32'h8000 + {24'b0, lf[15:8]} * 4;
      resolve(pc, tgt, tk, model_fetch(pc));
      i = int'(pc[N+1:2]);
      if (m_vld[i] && m_tag[i] == pc) begin
        m_tgt[i] = tgt; m_ctr[i] = sat(m_ctr[i], tk);
      end else if (tk) begin
        m_vld[i] = 1; m_tag[i] = pc; m_tgt[i] = tgt; m_ctr[i] = 2;
      end
      fetch_sweep("R2 R3 R4 target sweep");
    end

    // R4: explicit saturation on one branch
    do_reset();
    for (int n = 0; n < 5; n++) resolve(32'h1004, 32'h1100, 1, 32'h0);
    resolve(32'h1004, 32'h1100, 0, 32'h0);
    @(negedge clk); fetch_pc = 32'h1004; #1;
    chk("R4 saturate high", fetch_next, 32'h1100);
    for (int n = 0; n < 6; n++) resolve(32'h1004, 32'h1100, 0, 32'h0);
    resolve(32'h1004, 32'h1100, 1, 32'h0);
    @(negedge clk); #1;
    chk("R4 saturate low", fetch_next, 32'h1008);
    // R3: alias eviction
    resolve(32'h2004, 32'h2200, 1, 32'h0);
    @(negedge clk); #1;
    chk("R3 evicted", fetch_next, 32'h1008);
    @(negedge clk); fetch_pc = 32'h2004; #1;
    chk("R3 new entry", fetch_next, 32'h2200);

    // R6: static mode over offsets and kinds
    pred_mode = 1;
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 2; c++)
        for (int j = 0; j < 2; j++)
          for (int o = -2; o <= 2; o++) begin
            logic e;
            @(negedge clk);
            dec_valid = v[0]; dec_is_cond = c[0]; dec_is_jal = j[0];
            dec_pc = 32'h4000; dec_offset = 32'(o * 8); fetch_pc = 32'h2004; #1;
            e = v[0] && (j[0] || (c[0] && o < 0));
            chk("R6 static redirect", {31'b0, dec_redirect}, {31'b0, e});
            chk("R6 static target", dec_target, 32'h4000 + 32'(o * 8));
            chk("R6 no fetch redirect", {31'b0, fetch_taken}, 0);
          end

    // R7: history mode
    do_reset();
    pred_mode = 2;
    for (int it = 0; it < 300; it++) begin
      int k, i;
      logic tk;
      step_lf();
      k = int'(lf[2:0]); tk = lf[4] ^ (it % 37 < 18);
      resolve(pc_of(k), 32'h9000, tk, 32'h0);
      i = int'(pc_of(k) >> 2) % D;
      m_ctr[i] = sat(m_ctr[i], tk);
      for (int q = 0; q < 8; q++) begin
        @(negedge clk);
        dec_valid = 1; dec_pc = pc_of(q); dec_offset = 32'd16; fetch_pc = pc_of(q);
        dec_is_cond = 1; dec_is_jal = 0; #1;
        chk("R7 history cond", {31'b0, dec_redirect},
            {31'b0, m_ctr[int'(pc_of(q) >> 2) % D] >= 2});
        chk("R7 no fetch redirect", {31'b0, fetch_taken}, 0);
        dec_is_cond = 0; dec_is_jal = 1; #1;
        chk("R7 history jal", {31'b0, dec_redirect}, 1);
      end
    end
    dec_valid = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule